// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block holds the interrupt management state of a single hardware thread. It keeps four independent contexts, one each for hypervisor exceptions, operating-system exceptions, user-level event branches and doorbells. Each context collects presentation requests in an eight-bit pending map, one bit per priority. It reduces that map to the most favoured pending priority, where a smaller number is more favoured. It compares that priority against the thread's current priority and drives one interrupt line per context.

Software reaches the contexts through a small register window. The address carries a two-bit view number (ring 0 physical, ring 1 hypervisor, ring 2 OS, ring 3 user), a context select and a register select. A view may touch a context only if its ring number is not above the least privileged ring that the context admits. An acknowledge is a read of a dedicated register that takes the pending interrupt. Setting the current priority is a plain write.

Top module: `tip_presenter`

## Requirements
- R1: A presentation request with `pres_valid` high sets, at the next clock edge, bit `pres_prio` of the pending map of context `pres_ctx`. Contexts: 0 hypervisor, 1 OS, 2 user event branch, 3 doorbell.
- R2: The pending priority of a context is the index of the lowest set bit of its pending map, or 0xFF when the map is empty.
- R3: The notify bit (bit 7 of the source register) and `irq_o[c]` go high one cycle after the pending priority is numerically less than the current priority. They stay low when the pending priority is equal or larger.
- R4: A write to the current priority register takes effect at the next edge, and the compare uses the new value one cycle later, raising or lowering the line.
- R5: An acknowledge read with the notify bit set returns {source register, pending priority} as sampled before the read. It then clears that priority's pending bit, loads the current priority with it, and clears the notify bit and the line.
- R6: An acknowledge read with the notify bit clear returns {source register, pending priority} and changes no state.
- R7: Address layout is {view[5:4], context[3:2], register[1:0]}. Registers: 0 current priority (read/write), 1 status {source, pending priority} (read), 2 acknowledge (read), 3 pending map (read). The least privileged ring admitted is 1 for hypervisor, 2 for OS, 3 for user and 1 for doorbell. An access is allowed when view <= that ring.
- R8: A read through a view that is not allowed returns zero, and a write or acknowledge through it changes no state.
- R9: Requests, writes and acknowledges aimed at one context leave the others unchanged.
- R10: Synchronous active-high reset clears all pending maps, sets every current priority to 0, and drives `irq_o`, `rd_valid` and `rd_data` to zero.
- R11: Every read is answered one cycle later with `rd_valid` high and `rd_data`. Register 0 and register 3 return their 8-bit value zero-extended. Writes produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pres_valid | input | 1 | Presentation request strobe |
| pres_ctx | input | 2 | Target context of the request |
| pres_prio | input | 3 | Priority of the request |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | {view, context, register} |
| acc_wdata | input | 8 | Write data (current priority) |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 16 | Read answer |
| irq_o | output | 4 | Interrupt line per context |

## Verification
The assertions assume that access strobes are sampled as single-cycle commands. They also assume that a write only ever targets the current priority register, since writes elsewhere are discarded. The random stimulus writes current priorities in the range 0 to 9. This covers values on both sides of each pending priority, and values above the last valid priority. It mixes presentation requests with accesses from all four views, so allowed and rejected accesses occur against the same context state. Acknowledges are issued both while the line is high and while it is low.

// File: rtl/tip_pkg.sv
package tip_pkg;
    localparam int NUM_PRIO   = 8;
    localparam int PIDX_W     = $clog2(NUM_PRIO);
    localparam int PRIO_W     = 8;
    localparam int NUM_CTX    = 4;
    localparam int CTX_W      = $clog2(NUM_CTX);
    localparam int VIEW_W     = 2;
    localparam int RSEL_W     = 2;
    localparam int ADDR_W     = VIEW_W + CTX_W + RSEL_W;
    localparam int RD_W       = 2 * PRIO_W;
    localparam int NOTIFY_BIT = 7;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    typedef enum logic [RSEL_W-1:0] {
        RS_CUR  = 2'd0,
        RS_STAT = 2'd1,
        RS_ACK  = 2'd2,
        RS_PEND = 2'd3
    } rsel_e;

    typedef struct packed {
        logic [VIEW_W-1:0] view;
        logic [CTX_W-1:0]  ctx;
        rsel_e             rsel;
    } acc_addr_t;

    // least privileged ring admitted by each context
    function automatic logic [VIEW_W-1:0] ring_limit(input logic [CTX_W-1:0] c);
        case (c)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            2'd2:    return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    function automatic logic view_ok(input logic [VIEW_W-1:0] v,
                                     input logic [CTX_W-1:0] c);
        return v <= ring_limit(c);
    endfunction
endpackage

// File: rtl/tip_prio_find.sv
module tip_prio_find
    import tip_pkg::*;
#(
    parameter int N = NUM_PRIO
) (
    input  logic [N-1:0]      pend,
    output logic [PRIO_W-1:0] pipr
);
    always_comb begin
        pipr = PRIO_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) pipr = PRIO_W'(i);
        end
    end
endmodule

// File: rtl/tip_view_decode.sv
module tip_view_decode
    import tip_pkg::*;
(
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              allowed,
    output rsel_e             rsel,
    output logic [CTX_W-1:0]  ctx,
    output logic [NUM_CTX-1:0] cur_we,
    output logic [NUM_CTX-1:0] ack_rd
);
    acc_addr_t a;
    assign a       = acc_addr_t'(acc_addr);
    assign rsel    = a.rsel;
    assign ctx     = a.ctx;
    assign allowed = view_ok(a.view, a.ctx);

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_strb
        logic hit;
        assign hit       = acc_valid && allowed && (a.ctx == CTX_W'(c));
        assign cur_we[c] = hit && acc_write && (a.rsel == RS_CUR);
        assign ack_rd[c] = hit && !acc_write && (a.rsel == RS_ACK);
    end
endmodule

// File: rtl/tip_context.sv
module tip_context
    import tip_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                set_valid,
    input  logic [PIDX_W-1:0]   set_prio,
    input  logic                cur_we,
    input  logic [PRIO_W-1:0]   cur_wdata,
    input  logic                ack_rd,
    output logic [NUM_PRIO-1:0] pend,
    output logic [PRIO_W-1:0]   pipr,
    output logic [PRIO_W-1:0]   cppr,
    output logic                notify
);
    logic                ack_fire;
    logic [NUM_PRIO-1:0] clr_mask, set_mask;

    tip_prio_find #(.N(NUM_PRIO)) u_find (.pend(pend), .pipr(pipr));

    assign ack_fire = ack_rd && notify && (pend != '0);
    assign clr_mask = ack_fire ? (NUM_PRIO'(1) << pipr[PIDX_W-1:0]) : '0;
    assign set_mask = set_valid ? (NUM_PRIO'(1) << set_prio) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            cppr   <= '0;
            notify <= 1'b0;
        end else begin
            pend   <= (pend & ~clr_mask) | set_mask;
            notify <= ack_fire ? 1'b0 : (pipr < cppr);
            if (ack_fire)    cppr <= pipr;
            else if (cur_we) cppr <= cur_wdata;
        end
    end

    p_empty_none_r2: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (pipr == PRIO_NONE));
    p_rise_cmp_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(notify) |-> $past(pipr < cppr));
    p_ack_drop_r5: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> !notify);
    p_ack_cppr_r5: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> (cppr == $past(pipr)));
    p_quiet_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !notify && !cur_we && !set_valid) |=> $stable(pend) && $stable(cppr));
endmodule

// File: rtl/tip_presenter.sv
module tip_presenter
    import tip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pres_valid,
    input  logic [1:0]        pres_ctx,
    input  logic [2:0]        pres_prio,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [5:0]        acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [3:0]        irq_o
);
    logic                 allowed;
    rsel_e                rsel;
    logic [CTX_W-1:0]     ctx;
    logic [NUM_CTX-1:0]   cur_we, ack_rd;
    logic [NUM_PRIO-1:0]  pend_a [NUM_CTX];
    logic [PRIO_W-1:0]    pipr_a [NUM_CTX];
    logic [PRIO_W-1:0]    cppr_a [NUM_CTX];
    logic [NUM_CTX-1:0]   notify_a;

    tip_view_decode u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .allowed   (allowed),
        .rsel      (rsel),
        .ctx       (ctx),
        .cur_we    (cur_we),
        .ack_rd    (ack_rd)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        tip_context u_ctx (
            .clk       (clk),
            .rst       (rst),
            .set_valid (pres_valid && (pres_ctx == CTX_W'(c))),
            .set_prio  (pres_prio),
            .cur_we    (cur_we[c]),
            .cur_wdata (acc_wdata),
            .ack_rd    (ack_rd[c]),
            .pend      (pend_a[c]),
            .pipr      (pipr_a[c]),
            .cppr      (cppr_a[c]),
            .notify    (notify_a[c])
        );
    end

    assign irq_o = notify_a;

    logic [PRIO_W-1:0] src_reg;
    logic [RD_W-1:0]   rd_next;
    always_comb begin
        src_reg = '0;
        src_reg[NOTIFY_BIT] = notify_a[ctx];
        case (rsel)
            RS_CUR:  rd_next = {{PRIO_W{1'b0}}, cppr_a[ctx]};
            RS_PEND: rd_next = RD_W'(pend_a[ctx]);
            default: rd_next = {src_reg, pipr_a[ctx]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) rd_data <= allowed ? rd_next : '0;
        end
    end

    p_denied_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !view_ok(acc_addr[5:4], acc_addr[3:2]))
        |=> (rd_valid && rd_data == '0));
    p_write_silent_r11: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> !rd_valid);
    p_one_ack_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_rd));
endmodule

// File: tb/tip_presenter_tb_top.sv
`timescale 1ns/1ps
module tip_presenter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pres_valid = 1'b0;
    logic [1:0]  pres_ctx = '0;
    logic [2:0]  pres_prio = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [3:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tip_presenter dut_i (.*);

    // ---------------- reference model from requirements ----------------
    logic [7:0]  m_pend [4];
    logic [7:0]  m_cppr [4];
    logic        m_eo   [4];
    logic        e_rdv;
    logic [15:0] e_rd;

    function automatic logic [7:0] f_min(input logic [7:0] p);
        for (int i = 0; i < 8; i++) if (p[i]) return 8'(i);
        return 8'hFF;
    endfunction

    function automatic logic f_ok(input logic [1:0] v, input logic [1:0] c);
        logic [1:0] lim;
        lim = (c == 2'd1) ? 2'd2 : (c == 2'd2) ? 2'd3 : 2'd1;
        return v <= lim;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 4; c++) begin
                m_pend[c] = '0; m_cppr[c] = '0; m_eo[c] = 1'b0;
            end
            e_rdv = 1'b0; e_rd = '0;
        end else begin
            logic [1:0] v, c, r;
            logic ok;
            logic [7:0] pip [4];
            v = acc_addr[5:4]; c = acc_addr[3:2]; r = acc_addr[1:0];
            ok = f_ok(v, c);
            for (int k = 0; k < 4; k++) pip[k] = f_min(m_pend[k]);
            e_rdv = acc_valid && !acc_write;
            if (acc_valid && !acc_write) begin
                if (!ok) e_rd = '0;
                else if (r == 2'd0) e_rd = {8'h00, m_cppr[c]};
                else if (r == 2'd3) e_rd = {8'h00, m_pend[c]};
                else e_rd = {m_eo[c] ? 8'h80 : 8'h00, pip[c]};
            end
            for (int k = 0; k < 4; k++) begin
                logic ackf, wr;
                logic [7:0] np;
                ackf = acc_valid && !acc_write && ok && c == 2'(k) && r == 2'd2
                       && m_eo[k] && m_pend[k] != 0;
                wr   = acc_valid && acc_write && ok && c == 2'(k) && r == 2'd0;
                np   = m_pend[k];
                if (ackf) np[pip[k][2:0]] = 1'b0;
                if (pres_valid && pres_ctx == 2'(k)) np[pres_prio] = 1'b1;
                m_eo[k] = ackf ? 1'b0 : (pip[k] < m_cppr[k]);
                if (ackf) m_cppr[k] = pip[k];
                else if (wr) m_cppr[k] = acc_wdata;
                m_pend[k] = np;
            end
        end
    end

    // continuous comparison against the model, away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [3:0] eirq;
            for (int k = 0; k < 4; k++) eirq[k] = m_eo[k];
            checks++;
            if (irq_o !== eirq) begin
                errors++;
                $display("FAIL R3 irq_o act=%b exp=%b", irq_o, eirq);
            end
            checks++;
            if (rd_valid !== e_rdv || (e_rdv && rd_data !== e_rd)) begin
                errors++;
                $display("FAIL R11 rd act=%b/%h exp=%b/%h", rd_valid, rd_data, e_rdv, e_rd);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        pres_valid = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic present(input logic [1:0] c, input logic [2:0] p);
        pres_valid = 1'b1; pres_ctx = c; pres_prio = p; tick();
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d; tick();
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; tick();
        chk(16'(rd_valid), 16'h1, "R11 rd_valid");
        chk(rd_data, exp, tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unused;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        chk(16'(irq_o), 16'h0, "R10 irq after reset");
        chk(16'(rd_valid), 16'h0, "R10 rd_valid after reset");
        chk(rd_data, 16'h0, "R10 rd_data after reset");

        wr(6'h04, 8'd5);                 // ctx1 current = 5 via ring 0
        present(2'd1, 3'd3);
        tick();
        chk(16'(irq_o[1]), 16'h1, "R3 line raised 3<5");
        present(2'd1, 3'd6);
        tick();
        rd(6'h05, 16'h8003, "R2 status min of {3,6}");
        rd(6'h07, 16'h0048, "R1 pending map");
        rd(6'h26, 16'h8003, "R5 ack returns status");
        chk(16'(irq_o[1]), 16'h0, "R5 line dropped");
        rd(6'h04, 16'h0003, "R5 current loaded");
        rd(6'h07, 16'h0040, "R5 bit cleared");
        rd(6'h26, 16'h0006, "R6 ack without notify");
        rd(6'h07, 16'h0040, "R6 map unchanged");
        chk(16'(irq_o[1]), 16'h0, "R6 line low");

        wr(6'h04, 8'd7);
        tick();
        chk(16'(irq_o[1]), 16'h1, "R4 write raises line");
        wr(6'h04, 8'd0);
        tick();
        chk(16'(irq_o[1]), 16'h0, "R4 write lowers line");

        wr(6'h00, 8'd2);
        present(2'd0, 3'd2);
        tick(); tick();
        chk(16'(irq_o[0]), 16'h0, "R3 equal priority no line");

        rd(6'h31, 16'h0000, "R8 denied read zero");
        rd(6'h11, 16'h0002, "R7 ring1 view allowed on hyp ctx");
        wr(6'h20, 8'd9);
        rd(6'h00, 16'h0002, "R8 denied write ignored");
        rd(6'h0B, 16'h0000, "R9 ctx2 untouched");
        chk(16'(irq_o[2]), 16'h0, "R9 ctx2 line low");
        rd(6'h0D, 16'h00FF, "R2 empty reads FF");
        wr(6'h04, 8'd1);
        chk(16'(rd_valid), 16'h0, "R11 write gives no rd_valid");

        unused = $urandom(32'd2024);
        for (int n = 0; n < 4000; n++) begin
            pres_valid = ($urandom % 10) < 3;
            pres_ctx   = 2'($urandom);
            pres_prio  = 3'($urandom);
            acc_valid  = ($urandom % 10) < 4;
            acc_addr   = 6'($urandom);
            acc_write  = (acc_addr[1:0] == 2'd0) && ($urandom % 2 == 0);
            acc_wdata  = 8'($urandom % 10);
            @(posedge clk); #1;
        end
        pres_valid = 1'b0; acc_valid = 1'b0;
        tick(); tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule